// File: doc/BRIEF.md
# SPI Serial EEPROM Command Engine

This block is the protocol side of a small serial byte memory. It acts as an SPI slave in clock modes 0 and 3 and serves a 512-byte array held on chip. The three bus inputs (select, serial clock, data in) are brought into a fast system clock domain through synchronizers, and edges are found there. The serial clock must therefore run below a quarter of the system clock rate. The engine decodes a one-byte command, shifts in an address and data, and shifts out memory or status bytes. It handles streaming reads across the whole array and page writes of up to 16 bytes.

A separate status and protection block owns the write-enable latch, the protection level and the write-in-progress flag. The engine tells it about enable and disable commands with one-cycle pulses. It hands over each accepted programming operation with a one-cycle request, and it reads back a busy level and the status byte. Accepted page writes are staged in a 16-entry buffer with a valid flag per byte. Only the flagged bytes are copied into the array, one per cycle, once the request has gone out.

Top module: `spi_ee_engine`

## Requirements
- R1: Data in is taken on serial clock rising edges and data out changes on falling edges, most significant bit first, and every command works the same whether the clock idles low (mode 0) or high (mode 3).
- R2: Command byte 0000_A011 starts a read. Bit 3 of that byte (A) is address bit 8, and the next byte gives address bits 7..0. Bytes then stream out from that address, which increments after each byte and wraps from 0x1FF to 0x000.
- R3: Command byte 0000_x101 shifts out `sts_byte`, taken again at each byte boundary, for as long as select stays low. It also works while a programming cycle is running.
- R4: Command byte 0000_x110 gives one `wren_pulse` of one cycle, and 0000_x100 gives one `wrdi_pulse` of one cycle.
- R5: A command byte with a nonzero upper nibble, or with low bits 000 or 111, makes the engine ignore the bus until select goes high. No pulse, request or output enable follows.
- R6: Command byte 0000_A010, then an address byte, then whole data bytes, ended by select rising at a byte boundary, gives one `prog_req` cycle with `prog_to_status`=0 after deselection. The bytes received are written at consecutive addresses, and the other bytes stay unchanged.
- R7: Write bytes past the end of the 16-byte page continue from the start of that same page.
- R8: A write ended by select rising part-way through a byte is discarded: no request, and the array is unchanged.
- R9: Command byte 0000_x001 followed by one data byte, ended by select rising before the next serial rising edge, gives one `prog_req` cycle with `prog_to_status`=1 and `status_wdata` equal to that byte. Any further rising edge before deselection discards it.
- R10: While `prog_busy` is high or the buffer copy is running, read, write and status-write commands are ignored.
- R11: A write or status write commits only when `wr_enabled`=1. A write also needs its page to be outside the area set by `prot_lvl`: 01 protects addresses with bits 8:7 = 11, 10 protects those with bit 8 = 1, and 11 protects all addresses.
- R12: After reset the engine stays deselected until it sees a falling edge of select, so a select held low through reset selects nothing.
- R13: `spi_miso_oe` is low while select is high and whenever no read data is being shifted. It goes high from the first output bit of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Slave select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for the data-out pad |
| sts_byte | input | 8 | Status byte from the status block |
| wr_enabled | input | 1 | Write-enable latch state, already gated by the pin protect |
| prot_lvl | input | 2 | Protected-area selection |
| prog_busy | input | 1 | Programming cycle in progress in the status block |
| wren_pulse | output | 1 | Write-enable command seen |
| wrdi_pulse | output | 1 | Write-disable command seen |
| prog_req | output | 1 | Programming request, one cycle |
| prog_to_status | output | 1 | Request targets the status register (1) or the array (0) |
| status_wdata | output | 8 | Byte for the status register |

## Verification
The assertions watch several rules on every cycle. A programming request is a single cycle, is issued only after deselection, only when writing is enabled and never while busy. The two command pulses never overlap, and the output enable drops once select has been high for a few cycles. The content-level behaviour can only be shown by the bench's scenarios, which compare what comes out on the serial line against a behavioural memory model. These cover address increment and rollover, page wraparound, the byte-boundary commit rule, protected pages, commands ignored while busy and the post-reset select rule.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_RDATA, ST_WDATA, ST_SRDATA, ST_SRDONE, ST_HALT
  } eng_state_t;

  localparam logic [2:0] OP_WREN = 3'b110;
  localparam logic [2:0] OP_WRDI = 3'b100;
  localparam logic [2:0] OP_RDSR = 3'b101;
  localparam logic [2:0] OP_WRSR = 3'b001;
  localparam logic [2:0] OP_READ = 3'b011;
  localparam logic [2:0] OP_WRIT = 3'b010;
endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic mosi_s,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise,
  output logic cs_fall
);
  logic [STAGES:0]   cs_p, sck_p;
  logic [STAGES-1:0] mo_p;

  // select chain resets low so a select held low through reset gives no fall
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_p  <= '0;
      sck_p <= '0;
      mo_p  <= '0;
    end else begin
      cs_p  <= {cs_p[STAGES-1:0], cs_n};
      sck_p <= {sck_p[STAGES-1:0], sck};
      mo_p  <= {mo_p[STAGES-2:0], mosi};
    end
  end

  assign mosi_s   = mo_p[STAGES-1];
  assign sck_rise =  sck_p[STAGES-1] & ~sck_p[STAGES];
  assign sck_fall = ~sck_p[STAGES-1] &  sck_p[STAGES];
  assign cs_rise  =  cs_p[STAGES-1]  & ~cs_p[STAGES];
  assign cs_fall  = ~cs_p[STAGES-1]  &  cs_p[STAGES];
endmodule

// File: rtl/spi_ee_pagebuf.sv
module spi_ee_pagebuf #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] widx,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(DEPTH)-1:0] ridx,
  output logic [DW-1:0]            rdata,
  output logic                     rvld
);
  logic [DW-1:0]    slot [DEPTH];
  logic [DEPTH-1:0] vld;

  always_ff @(posedge clk) begin
    if (rst || clr) vld <= '0;
    else if (we)    vld[widx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we) slot[widx] <= wdata;
  end

  assign rdata = slot[ridx];
  assign rvld  = vld[ridx];
endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  // erased state: all ones
  initial for (int i = 0; i < DEPTH; i++) mem[i] = '1;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spi_ee_engine.sv
module spi_ee_engine
  import spi_ee_pkg::*;
#(
  parameter int AW   = 9,
  parameter int PAGE = 16,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       spi_cs_n,
  input  logic       spi_sck,
  input  logic       spi_mosi,
  output logic       spi_miso,
  output logic       spi_miso_oe,
  input  logic [7:0] sts_byte,
  input  logic       wr_enabled,
  input  logic [1:0] prot_lvl,
  input  logic       prog_busy,
  output logic       wren_pulse,
  output logic       wrdi_pulse,
  output logic       prog_req,
  output logic       prog_to_status,
  output logic [7:0] status_wdata
);
  localparam int IW = $clog2(PAGE);
  localparam int PW = AW - IW;

  logic mosi_s, sck_rise, sck_fall, cs_rise, cs_fall;
  eng_state_t st;
  logic [2:0]    bcnt, ocnt;
  logic [7:0]    sh, out_sh;
  logic [7:0]    nxt;
  logic [8:0]    a9;
  logic          a8, is_wr, got_byte, rd_status, copying, buf_clr;
  logic [1:0]    pend;
  logic [AW-1:0] rd_addr;
  logic [IW-1:0] col, cidx;
  logic [PW-1:0] wpage, cpage;
  logic [7:0]    arr_q, buf_q;
  logic          buf_v, buf_we, busy, wprot, wr_ok;

  spi_ee_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst(rst), .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi),
    .mosi_s(mosi_s), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_rise(cs_rise), .cs_fall(cs_fall));

  spi_ee_pagebuf #(.DEPTH(PAGE), .DW(8)) u_buf (
    .clk(clk), .rst(rst), .clr(buf_clr), .we(buf_we), .widx(col), .wdata(nxt),
    .ridx(cidx), .rdata(buf_q), .rvld(buf_v));

  spi_ee_array #(.AW(AW), .DW(8)) u_arr (
    .clk(clk), .we(copying && buf_v), .waddr({cpage, cidx}), .wdata(buf_q),
    .raddr(rd_addr), .rdata(arr_q));

  assign nxt    = {sh[6:0], mosi_s};
  assign a9     = {a8, nxt};
  assign busy   = prog_busy || copying;
  assign buf_we = (st == ST_WDATA) && sck_rise && (bcnt == 3'd7) && !cs_rise && !cs_fall;

  // protected area: top quarter, upper half or everything
  always_comb begin
    unique case (prot_lvl)
      2'b00:   wprot = 1'b0;
      2'b01:   wprot = wpage[PW-1] && wpage[PW-2];
      2'b10:   wprot = wpage[PW-1];
      default: wprot = 1'b1;
    endcase
  end

  assign wr_ok = (st == ST_WDATA) && (bcnt == 3'd0) && got_byte &&
                 wr_enabled && !busy && !wprot;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; bcnt <= '0; ocnt <= '0; sh <= '0; out_sh <= '0;
      a8 <= 1'b0; is_wr <= 1'b0; got_byte <= 1'b0; rd_status <= 1'b0;
      copying <= 1'b0; buf_clr <= 1'b0; pend <= '0; rd_addr <= '0;
      col <= '0; cidx <= '0; wpage <= '0; cpage <= '0;
      spi_miso <= 1'b0; spi_miso_oe <= 1'b0;
      wren_pulse <= 1'b0; wrdi_pulse <= 1'b0; prog_req <= 1'b0;
      prog_to_status <= 1'b0; status_wdata <= '0;
    end else begin
      wren_pulse <= 1'b0;
      wrdi_pulse <= 1'b0;
      prog_req   <= 1'b0;
      buf_clr    <= 1'b0;
      if (copying) begin
        cidx <= cidx + 1'b1;
        if (cidx == IW'(PAGE - 1)) copying <= 1'b0;
      end
      if (cs_rise) begin
        if (wr_ok) begin
          prog_req <= 1'b1; prog_to_status <= 1'b0;
          copying <= 1'b1; cidx <= '0; cpage <= wpage;
        end else if (st == ST_SRDONE && wr_enabled && !busy) begin
          prog_req <= 1'b1; prog_to_status <= 1'b1; status_wdata <= sh;
        end
        st <= ST_IDLE;
        spi_miso_oe <= 1'b0;
      end else if (cs_fall) begin
        st <= ST_OPC; bcnt <= '0; got_byte <= 1'b0; spi_miso_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_OPC: if (sck_rise) begin
            sh <= nxt; bcnt <= bcnt + 1'b1;
            if (bcnt == 3'd7) begin
              st <= ST_HALT;
              if (nxt[7:4] == 4'h0) begin
                unique case (nxt[2:0])
                  OP_WREN: wren_pulse <= 1'b1;
                  OP_WRDI: wrdi_pulse <= 1'b1;
                  OP_RDSR: begin
                    st <= ST_RDATA; rd_status <= 1'b1; out_sh <= sts_byte;
                    ocnt <= '0; pend <= '0;
                  end
                  OP_WRSR: if (!busy) st <= ST_SRDATA;
                  OP_READ: if (!busy) begin st <= ST_ADDR; is_wr <= 1'b0; a8 <= nxt[3]; end
                  OP_WRIT: if (!busy) begin
                    st <= ST_ADDR; is_wr <= 1'b1; a8 <= nxt[3]; buf_clr <= 1'b1;
                  end
                  default: st <= ST_HALT;
                endcase
              end
            end
          end
          ST_ADDR: if (sck_rise) begin
            sh <= nxt; bcnt <= bcnt + 1'b1;
            if (bcnt == 3'd7) begin
              if (is_wr) begin
                st <= ST_WDATA; col <= a9[IW-1:0]; wpage <= a9[AW-1:IW];
              end else begin
                st <= ST_RDATA; rd_addr <= a9[AW-1:0]; pend <= 2'd2;
                rd_status <= 1'b0; ocnt <= '0;
              end
            end
          end
          ST_RDATA: begin
            if (pend != 2'd0) begin
              pend <= pend - 1'b1;
              if (pend == 2'd1) begin out_sh <= arr_q; rd_addr <= rd_addr + 1'b1; end
            end else if (sck_fall) begin
              spi_miso <= out_sh[7]; spi_miso_oe <= 1'b1; ocnt <= ocnt + 1'b1;
              if (ocnt == 3'd7) begin
                out_sh <= rd_status ? sts_byte : arr_q;
                if (!rd_status) rd_addr <= rd_addr + 1'b1;
              end else begin
                out_sh <= {out_sh[6:0], 1'b0};
              end
            end
          end
          ST_WDATA: if (sck_rise) begin
            sh <= nxt; bcnt <= bcnt + 1'b1;
            if (bcnt == 3'd7) begin col <= col + 1'b1; got_byte <= 1'b1; end
          end
          ST_SRDATA: if (sck_rise) begin
            sh <= nxt; bcnt <= bcnt + 1'b1;
            if (bcnt == 3'd7) st <= ST_SRDONE;
          end
          ST_SRDONE: if (sck_rise) st <= ST_HALT;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_ee_engine_chk.sv
module spi_ee_engine_chk (
  input logic clk,
  input logic rst,
  input logic spi_cs_n,
  input logic spi_miso_oe,
  input logic wren_pulse,
  input logic wrdi_pulse,
  input logic prog_req,
  input logic wr_enabled,
  input logic prog_busy
);
  assert_oe_desel_R13: assert property (@(posedge clk) disable iff (rst)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_miso_oe);

  assert_req_single_R6: assert property (@(posedge clk) disable iff (rst)
    prog_req |=> !prog_req);

  assert_req_after_desel_R6: assert property (@(posedge clk) disable iff (rst)
    prog_req |-> spi_cs_n);

  assert_req_enabled_R11: assert property (@(posedge clk) disable iff (rst)
    prog_req |-> wr_enabled);

  assert_req_not_busy_R10: assert property (@(posedge clk) disable iff (rst)
    prog_req |-> !prog_busy);

  assert_pulse_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(wren_pulse && wrdi_pulse));

  assert_wren_single_R4: assert property (@(posedge clk) disable iff (rst)
    wren_pulse |=> !wren_pulse);
endmodule

bind spi_ee_engine spi_ee_engine_chk u_chk (
  .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_miso_oe(spi_miso_oe),
  .wren_pulse(wren_pulse), .wrdi_pulse(wrdi_pulse), .prog_req(prog_req),
  .wr_enabled(wr_enabled), .prog_busy(prog_busy));

// File: tb/spi_ee_engine_tb.sv
`timescale 1ns/1ps
module spi_ee_engine_tb;
  localparam int H    = 6;     // serial half period in system clocks
  localparam int BUSY = 2000;  // programming time of the modelled status block
  localparam int WD   = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b0, sck = 1'b0, mosi = 1'b0;
  logic spi_miso, spi_miso_oe, wren_pulse, wrdi_pulse, prog_req, prog_to_status;
  logic [7:0] status_wdata;
  logic wel = 1'b0;
  logic [1:0] bp = 2'b00;
  int busy_cnt = 0;
  logic prog_busy;
  logic [7:0] sts;

  always #10 clk = ~clk;

  assign prog_busy = (busy_cnt != 0);
  assign sts = {4'hF, bp, wel, prog_busy};

  spi_ee_engine u_dut (
    .clk(clk), .rst(rst), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe), .sts_byte(sts),
    .wr_enabled(wel), .prot_lvl(bp), .prog_busy(prog_busy),
    .wren_pulse(wren_pulse), .wrdi_pulse(wrdi_pulse), .prog_req(prog_req),
    .prog_to_status(prog_to_status), .status_wdata(status_wdata));

  // behavioural status/protection neighbour and event counters
  int req_cnt = 0, wren_cnt = 0, wrdi_cnt = 0;
  logic last_sel = 1'b0;
  logic [7:0] last_sr = 8'h00;
  always @(posedge clk) begin
    if (rst) begin
      wel <= 1'b0; bp <= 2'b00; busy_cnt <= 0;
    end else begin
      if (wren_pulse) begin wel <= 1'b1; wren_cnt++; end
      if (wrdi_pulse) begin wel <= 1'b0; wrdi_cnt++; end
      if (prog_req) begin
        req_cnt++; last_sel = prog_to_status; last_sr = status_wdata;
        wel <= 1'b0; busy_cnt <= BUSY;
        if (prog_to_status) bp <= status_wdata[3:2];
      end else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    end
  end

  // per-clock check of the enable against the deselect rule (R13)
  int hi_run = 0, oe_viol = 0;
  always @(negedge clk) begin
    if (cs_n) hi_run++; else hi_run = 0;
    if (!rst && hi_run >= 4 && spi_miso_oe) oe_viol++;
  end

  int checks = 0, bad = 0;
  bit finished = 0;
  logic [7:0] mdl [512];
  logic [7:0] wdat [16];
  logic [7:0] rbuf [16];
  logic rd_oe;
  logic oe_seen;
  bit mode3 = 0;

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; mosi = tx[i]; tick(H);
      rx[i] = spi_miso;
      if (spi_miso_oe) oe_seen = 1'b1;
      sck = 1'b1; tick(H);
    end
  endtask

  task automatic bits(input int n);
    for (int i = 0; i < n; i++) begin
      sck = 1'b0; mosi = 1'b0; tick(H); sck = 1'b1; tick(H);
    end
  endtask

  task automatic t_begin;
    sck = mode3; tick(2); cs_n = 1'b0; oe_seen = 1'b0; tick(H);
  endtask

  task automatic t_end;
    if (!mode3) begin sck = 1'b0; tick(H); end
    cs_n = 1'b1; tick(2 * H);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] d;
    t_begin; xfer(op, d); t_end;
  endtask

  task automatic rd(input logic [8:0] a, input int n);
    logic [7:0] d;
    t_begin;
    xfer({4'h0, a[8], 3'b011}, d);
    xfer(a[7:0], d);
    rd_oe = 1'b1;
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, rbuf[k]);
      if (!spi_miso_oe) rd_oe = 1'b0;
    end
    t_end;
  endtask

  task automatic rdsr(input int n);
    logic [7:0] d;
    t_begin;
    xfer(8'h05, d);
    for (int k = 0; k < n; k++) xfer(8'h00, rbuf[k]);
    t_end;
  endtask

  task automatic wr(input logic [8:0] a, input int n, input int extra);
    logic [7:0] d;
    t_begin;
    xfer({4'h0, a[8], 3'b010}, d);
    xfer(a[7:0], d);
    for (int k = 0; k < n; k++) xfer(wdat[k], d);
    bits(extra);
    t_end;
  endtask

  task automatic wrsr(input logic [7:0] v, input int extra);
    logic [7:0] d;
    t_begin; xfer(8'h01, d); xfer(v, d); bits(extra); t_end;
  endtask

  task automatic model_write(input logic [8:0] a, input int n);
    for (int k = 0; k < n; k++)
      mdl[{a[8:4], 4'(a[3:0] + k)}] = wdat[k];
  endtask

  task automatic settle;
    tick(8);
    while (prog_busy) tick(1);
    tick(24);
  endtask

  task automatic rd_cmp(input string tag, input logic [8:0] a, input int n);
    rd(a, n);
    for (int k = 0; k < n; k++) chk(tag, rbuf[k], mdl[9'(a + k)]);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    $display("FAIL watchdog actual=running expected=finished");
    checks++; bad++;
    summary;
  end

  initial begin
    int r0;
    for (int i = 0; i < 512; i++) mdl[i] = 8'hFF;

    // R12: select held low through reset; traffic must be ignored
    tick(5); rst = 1'b0; tick(2);
    chk("R13 reset oe", spi_miso_oe, 0);
    chk("R6 reset req", prog_req, 0);
    oe_seen = 1'b0;
    begin
      logic [7:0] d;
      xfer(8'h06, d); xfer(8'h03, d); xfer(8'h00, d); xfer(8'h00, d);
    end
    sck = 1'b0; tick(H); cs_n = 1'b1; tick(2 * H);
    chk("R12 no wren before cs fall", wren_cnt, 0);
    chk("R12 no output before cs fall", oe_seen, 0);

    // R4, R6: single write, R2 A8 from opcode
    cmd(8'h06);
    chk("R4 wren pulse count", wren_cnt, 1);
    wdat[0] = 8'h11; wdat[1] = 8'h22; wdat[2] = 8'h33;
    r0 = req_cnt;
    wr(9'h105, 3, 0);
    chk("R6 write request", req_cnt, r0 + 1);
    chk("R6 request target array", last_sel, 0);
    model_write(9'h105, 3);
    settle;
    rd_cmp("R6 R2 read back upper half", 9'h104, 5);
    chk("R13 oe during read data", rd_oe, 1);

    // R1, R7: mode 3 with page wraparound
    mode3 = 1;
    sck = 1'b1; tick(H);
    cmd(8'h06);
    wdat[0] = 8'hA0; wdat[1] = 8'hA1; wdat[2] = 8'hA2; wdat[3] = 8'hA3;
    r0 = req_cnt;
    wr(9'h0FE, 4, 0);
    chk("R1 mode3 write request", req_cnt, r0 + 1);
    model_write(9'h0FE, 4);
    settle;
    rd_cmp("R7 page wrap start", 9'h0F0, 3);
    rd_cmp("R1 R7 page end then next page", 9'h0FE, 3);
    mode3 = 0;
    sck = 1'b0; tick(H);

    // R8: select rises mid-byte
    cmd(8'h06);
    wdat[0] = 8'h55; r0 = req_cnt;
    wr(9'h020, 1, 3);
    chk("R8 partial byte discarded", req_cnt, r0);
    rd_cmp("R8 array unchanged", 9'h020, 1);

    // R2 rollover from top address to zero
    cmd(8'h06); wdat[0] = 8'h77; wr(9'h1FF, 1, 0); model_write(9'h1FF, 1); settle;
    cmd(8'h06); wdat[0] = 8'h99; wr(9'h000, 1, 0); model_write(9'h000, 1); settle;
    rd(9'h1FF, 2);
    chk("R2 top byte", rbuf[0], 8'h77);
    chk("R2 rollover to zero", rbuf[1], 8'h99);

    // R3 status read repeats
    rdsr(2);
    chk("R3 status first", rbuf[0], {4'hF, 2'b00, 1'b0, 1'b0});
    chk("R3 status repeated", rbuf[1], {4'hF, 2'b00, 1'b0, 1'b0});

    // R10: commands during a programming cycle
    cmd(8'h06); wdat[0] = 8'h5A; wr(9'h060, 1, 0); model_write(9'h060, 1);
    rdsr(1);
    chk("R3 status during busy", rbuf[0], {4'hF, 2'b00, 1'b0, 1'b1});
    rd(9'h060, 2);
    chk("R10 read ignored while busy", oe_seen, 0);
    cmd(8'h06); wdat[0] = 8'hC3; r0 = req_cnt;
    wr(9'h061, 1, 0);
    wrsr(8'h0C, 0);
    chk("R10 write and wrsr ignored while busy", req_cnt, r0);
    settle;
    rd_cmp("R10 array after busy", 9'h060, 2);

    // R5: invalid command codes
    r0 = wren_cnt;
    begin
      logic [7:0] d;
      t_begin; xfer(8'h46, d); xfer(8'h06, d); t_end;
      t_begin; xfer(8'h07, d); xfer(8'h03, d); xfer(8'h00, d); t_end;
    end
    chk("R5 invalid code ignored", wren_cnt, r0);
    chk("R5 no output after invalid", oe_seen, 0);

    // R4, R11: disabled latch blocks writes
    cmd(8'h06); cmd(8'h04);
    chk("R4 wrdi pulse count", wrdi_cnt, 1);
    wdat[0] = 8'h3C; r0 = req_cnt;
    wr(9'h070, 1, 0);
    chk("R11 no commit without enable", req_cnt, r0);
    rd_cmp("R11 unchanged without enable", 9'h070, 1);

    // R9: status write, then R11 protected upper half
    cmd(8'h06); r0 = req_cnt;
    wrsr(8'h08, 0);
    chk("R9 status request", req_cnt, r0 + 1);
    chk("R9 request target status", last_sel, 1);
    chk("R9 status data", last_sr, 8'h08);
    settle;
    cmd(8'h06); r0 = req_cnt;
    wrsr(8'h00, 1);
    chk("R9 late deselect discarded", req_cnt, r0);
    cmd(8'h04);
    rdsr(1);
    chk("R9 protection level kept", rbuf[0], 8'hF8);
    cmd(8'h06); wdat[0] = 8'hE1; r0 = req_cnt;
    wr(9'h150, 1, 0);
    chk("R11 protected half refused", req_cnt, r0);
    cmd(8'h04);
    cmd(8'h06); wdat[0] = 8'hE2;
    wr(9'h050, 1, 0);
    chk("R11 lower half accepted", req_cnt, r0 + 1);
    model_write(9'h050, 1);
    settle;
    rd_cmp("R11 lower half data", 9'h050, 1);
    rd_cmp("R11 protected byte unchanged", 9'h150, 1);

    // R11 top-quarter level
    cmd(8'h06); wrsr(8'h04, 0); settle;
    cmd(8'h06); wdat[0] = 8'hB4; r0 = req_cnt;
    wr(9'h180, 1, 0);
    chk("R11 top quarter refused", req_cnt, r0);
    cmd(8'h04);
    cmd(8'h06); wr(9'h100, 1, 0);
    chk("R11 below top quarter accepted", req_cnt, r0 + 1);
    model_write(9'h100, 1);
    settle;
    rd_cmp("R11 quarter boundary data", 9'h100, 1);

    chk("R13 oe low while deselected", oe_viol, 0);
    summary;
  end
endmodule